// File: doc/BRIEF.md
# Writable Lookup-Table Pair

This block is a pair of small truth-table cells, A and B, each holding 64 one-bit entries selected directly by a 6-bit logic-input address. The addressed entry appears on the output combinationally, so a loaded table makes each cell compute any 6-input function. Cell A also gives a second output taken from the lower half of its table. With that output, the cell works as two 5-input functions that share five inputs.

A mode input lets user logic rewrite the tables at run time. In memory mode, cell A is a 64-entry single-port RAM. In shift mode, the lower 32 entries of cell A form a serial shift register with an addressable tap and a cascade output. In dual-port mode, both cells take the same write, so the pair acts as one 64-entry memory with a second, independent read address. A configuration port loads single bits of either table, whatever the mode.

The write port is a plain synchronous strobe and has no ready signal. There is no back-pressure: every cycle with the write enable high is consumed at the next rising edge.

Top module: `wlut_pair`

## Requirements
- R1: An active-low reset (rst_n = 0) clears every entry of both tables, so all outputs read 0 after reset.
- R2: In mode 0 (LUT), out_a = table_A[addr_a] and out_b = table_B[addr_b], combinationally, for every address.
- R3: In mode 0, a user write (we = 1) changes neither table.
- R4: In mode 1 (RAM), we = 1 writes wdata into table_A[addr_a] at the rising edge. A read of that address in any later cycle returns the new bit. Table B is unchanged.
- R5: In mode 2 (SHIFT), we = 1 shifts the lower 32 entries of table A by one place. Entry 0 takes shift_in and entry k takes the old entry k-1. Entries 32..63 are kept. In this mode out_a shows the tap table_A[addr_a[4:0]], and addr_a[5] is ignored.
- R6: shift_out always equals table_A[31], the last stage of the shift region. With we = 0 and cfg_en = 0, no table changes in any mode.
- R7: out_a5 = table_A[{0, addr_a[4:0]}] in every mode. With addr_a[5] = 1, out_a gives the upper-half function and out_a5 gives the lower-half function.
- R8: In mode 3 (DUAL), we = 1 writes wdata at addr_a into both tables. out_b reads table B at addr_b, independently of addr_a.
- R9: cfg_en = 1 writes cfg_bit into entry cfg_addr of table A (cfg_cell = 0) or table B (cfg_cell = 1) at the rising edge, in any mode. It blocks every user write or shift in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0 LUT, 1 RAM, 2 SHIFT, 3 DUAL |
| addr_a | input | 6 | Logic inputs / read-write address of cell A |
| addr_b | input | 6 | Logic inputs / second read address of cell B |
| we | input | 1 | User write or shift enable |
| wdata | input | 1 | User write data |
| shift_in | input | 1 | Serial input of the shift register |
| cfg_en | input | 1 | Configuration write strobe |
| cfg_cell | input | 1 | Configuration target: 0 cell A, 1 cell B |
| cfg_addr | input | 6 | Configuration entry address |
| cfg_bit | input | 1 | Configuration data |
| out_a | output | 1 | Cell A output (full function or shift tap) |
| out_a5 | output | 1 | Cell A lower-half 5-input output |
| out_b | output | 1 | Cell B output |
| shift_out | output | 1 | Cascade output, last shift stage |

## Verification
All four outputs are combinational in the addresses and mode, so a read is due in the same cycle that its address is applied. A write, shift or configuration load shows up in the cycle after the rising edge that commits it. The bench drives inputs 1 ns after a rising edge and samples the outputs at the following falling edge. Its reference tables are updated only at the edge where the previous cycle's write takes effect. As a result, every write-then-read pair, in each of the four modes, is checked exactly one cycle after the write.

// File: rtl/wlut_pkg.sv
package wlut_pkg;

  typedef enum logic [1:0] {
    MODE_LUT   = 2'd0,
    MODE_RAM   = 2'd1,
    MODE_SHIFT = 2'd2,
    MODE_DUAL  = 2'd3
  } wlut_mode_e;

  typedef struct packed {
    logic a_cfg_we;
    logic b_cfg_we;
    logic a_wr_en;
    logic a_sh_en;
    logic b_wr_en;
  } wlut_ctl_t;

endpackage

// File: rtl/wlut_ctrl.sv
module wlut_ctrl
  import wlut_pkg::*;
(
  input  wlut_mode_e mode,
  input  logic       we,
  input  logic       cfg_en,
  input  logic       cfg_cell,
  output wlut_ctl_t  ctl
);

  logic user_ok;

  // Configuration owns the cycle; user writes proceed only without it.
  assign user_ok = we & ~cfg_en;

  always_comb begin
    ctl          = '0;
    ctl.a_cfg_we = cfg_en & ~cfg_cell;
    ctl.b_cfg_we = cfg_en &  cfg_cell;
    unique case (mode)
      MODE_LUT:   ;
      MODE_RAM:   ctl.a_wr_en = user_ok;
      MODE_SHIFT: ctl.a_sh_en = user_ok;
      MODE_DUAL: begin
        ctl.a_wr_en = user_ok;
        ctl.b_wr_en = user_ok;
      end
      default:    ;
    endcase
  end

endmodule

// File: rtl/wlut_store.sv
module wlut_store #(
  parameter int ADDR_W    = 6,
  parameter int SHIFT_LEN = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic                     cfg_bit,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic                     wr_bit,
  input  logic                     sh_en,
  input  logic                     sh_in,
  output logic [(1<<ADDR_W)-1:0]   bits
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0]     nxt;
  logic [SHIFT_LEN-1:0] shifted;

  generate
    if (SHIFT_LEN > 1) begin : g_chain
      assign shifted = {bits[SHIFT_LEN-2:0], sh_in};
    end else begin : g_single
      assign shifted = sh_in;
    end
  endgenerate

  always_comb begin
    nxt = bits;
    if (cfg_we) begin
      nxt[cfg_addr] = cfg_bit;
    end else if (sh_en) begin
      nxt[SHIFT_LEN-1:0] = shifted;
    end else if (wr_en) begin
      nxt[wr_addr] = wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= nxt;
  end

endmodule

// File: rtl/wlut_read.sv
module wlut_read #(
  parameter int ADDR_W = 6
) (
  input  logic [(1<<ADDR_W)-1:0] bits,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   full,
  output logic                   half
);

  assign full = bits[addr];
  assign half = bits[{1'b0, addr[ADDR_W-2:0]}];

endmodule

// File: rtl/wlut_pair.sv
module wlut_pair #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              we,
  input  logic              wdata,
  input  logic              shift_in,
  input  logic              cfg_en,
  input  logic              cfg_cell,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_bit,
  output logic              out_a,
  output logic              out_a5,
  output logic              out_b,
  output logic              shift_out
);
  import wlut_pkg::*;

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int SHIFT_LEN = DEPTH / 2;

  wlut_mode_e       mode_e;
  wlut_ctl_t        ctl;
  logic [DEPTH-1:0] bits_a;
  logic [DEPTH-1:0] bits_b;
  logic [ADDR_W-1:0] rd_addr_a;
  logic             b_half_unused;

  assign mode_e = wlut_mode_e'(mode);

  wlut_ctrl u_ctrl (
    .mode     (mode_e),
    .we       (we),
    .cfg_en   (cfg_en),
    .cfg_cell (cfg_cell),
    .ctl      (ctl)
  );

  wlut_store #(.ADDR_W(ADDR_W), .SHIFT_LEN(SHIFT_LEN)) u_store_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (ctl.a_cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_bit  (cfg_bit),
    .wr_en    (ctl.a_wr_en),
    .wr_addr  (addr_a),
    .wr_bit   (wdata),
    .sh_en    (ctl.a_sh_en),
    .sh_in    (shift_in),
    .bits     (bits_a)
  );

  wlut_store #(.ADDR_W(ADDR_W), .SHIFT_LEN(SHIFT_LEN)) u_store_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (ctl.b_cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_bit  (cfg_bit),
    .wr_en    (ctl.b_wr_en),
    .wr_addr  (addr_a),
    .wr_bit   (wdata),
    .sh_en    (1'b0),
    .sh_in    (1'b0),
    .bits     (bits_b)
  );

  // In shift mode the top address bit is dropped: the tap stays in the chain.
  assign rd_addr_a = (mode_e == MODE_SHIFT) ? {1'b0, addr_a[ADDR_W-2:0]} : addr_a;

  wlut_read #(.ADDR_W(ADDR_W)) u_read_a (
    .bits (bits_a),
    .addr (rd_addr_a),
    .full (out_a),
    .half ()
  );

  wlut_read #(.ADDR_W(ADDR_W)) u_read_a5 (
    .bits (bits_a),
    .addr (addr_a),
    .full (),
    .half (out_a5)
  );

  wlut_read #(.ADDR_W(ADDR_W)) u_read_b (
    .bits (bits_b),
    .addr (addr_b),
    .full (out_b),
    .half (b_half_unused)
  );

  assign shift_out = bits_a[SHIFT_LEN-1];

endmodule

// File: rtl/wlut_pair_chk.sv
module wlut_pair_chk #(
  parameter int ADDR_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             mode,
  input logic [ADDR_W-1:0]      addr_a,
  input logic                   we,
  input logic                   wdata,
  input logic                   shift_in,
  input logic                   cfg_en,
  input logic                   cfg_cell,
  input logic [ADDR_W-1:0]      cfg_addr,
  input logic                   cfg_bit,
  input logic                   shift_out,
  input logic [(1<<ADDR_W)-1:0] bits_a,
  input logic [(1<<ADDR_W)-1:0] bits_b
);

  localparam int SHIFT_LEN = (1 << ADDR_W) / 2;

  // R3
  lut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !cfg_en) |=> ($stable(bits_a) && $stable(bits_b)));

  // R4
  ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && we && !cfg_en) |=>
      (bits_a[$past(addr_a)] == $past(wdata) && $stable(bits_b)));

  // R5
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && we && !cfg_en) |=>
      (bits_a[0] == $past(shift_in) && shift_out == $past(bits_a[SHIFT_LEN-2])));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !cfg_en) |=> ($stable(bits_a) && $stable(bits_b)));

  // R8
  dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && we && !cfg_en) |=>
      (bits_a[$past(addr_a)] == $past(wdata) && bits_b[$past(addr_a)] == $past(wdata)));

  // R9
  cfg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_cell) |=> (bits_a[$past(cfg_addr)] == $past(cfg_bit) && $stable(bits_b)));

  // R9
  cfg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_cell) |=> (bits_b[$past(cfg_addr)] == $past(cfg_bit) && $stable(bits_a)));

endmodule

bind wlut_pair wlut_pair_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .addr_a    (addr_a),
  .we        (we),
  .wdata     (wdata),
  .shift_in  (shift_in),
  .cfg_en    (cfg_en),
  .cfg_cell  (cfg_cell),
  .cfg_addr  (cfg_addr),
  .cfg_bit   (cfg_bit),
  .shift_out (shift_out),
  .bits_a    (bits_a),
  .bits_b    (bits_b)
);

// File: tb/wlut_pair_tb.sv
module wlut_pair_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [5:0] addr_a = '0, addr_b = '0, cfg_addr = '0;
  logic       we = 1'b0, wdata = 1'b0, shift_in = 1'b0;
  logic       cfg_en = 1'b0, cfg_cell = 1'b0, cfg_bit = 1'b0;
  logic       out_a, out_a5, out_b, shift_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [63:0] ma = '0, mb = '0;
  logic [3:0]  exp_q[$];
  string       tag_q[$];

  // values of the previous step, committed at the next rising edge
  logic [1:0] p_mode = 2'd0;
  logic [5:0] p_aa = '0, p_ca = '0;
  logic       p_we = 1'b0, p_wd = 1'b0, p_si = 1'b0, p_ce = 1'b0, p_cc = 1'b0, p_cb = 1'b0;

  always #2 clk = ~clk;

  wlut_pair u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr_a(addr_a), .addr_b(addr_b),
    .we(we), .wdata(wdata), .shift_in(shift_in), .cfg_en(cfg_en),
    .cfg_cell(cfg_cell), .cfg_addr(cfg_addr), .cfg_bit(cfg_bit),
    .out_a(out_a), .out_a5(out_a5), .out_b(out_b), .shift_out(shift_out)
  );

  // Reference update from the requirements (R3, R4, R5, R8, R9).
  task automatic commit_prev();
    if (p_ce) begin
      if (p_cc) mb[p_ca] = p_cb;
      else      ma[p_ca] = p_cb;
    end else if (p_we) begin
      case (p_mode)
        2'd1: ma[p_aa] = p_wd;
        2'd2: ma[31:0] = {ma[30:0], p_si};
        2'd3: begin ma[p_aa] = p_wd; mb[p_aa] = p_wd; end
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [5:0] aa, input logic [5:0] ab,
                      input logic w, input logic wd, input logic si,
                      input logic ce, input logic cc, input logic [5:0] ca, input logic cb,
                      input string tag);
    logic [5:0] ta;
    @(posedge clk);
    commit_prev();
    #1;
    mode = m; addr_a = aa; addr_b = ab; we = w; wdata = wd; shift_in = si;
    cfg_en = ce; cfg_cell = cc; cfg_addr = ca; cfg_bit = cb;
    p_mode = m; p_aa = aa; p_we = w; p_wd = wd; p_si = si;
    p_ce = ce; p_cc = cc; p_ca = ca; p_cb = cb;
    ta = (m == 2'd2) ? {1'b0, aa[4:0]} : aa;
    exp_q.push_back({ma[ta], ma[{1'b0, aa[4:0]}], mb[ab], ma[31]});
    tag_q.push_back(tag);
  endtask

  task automatic rd(input logic [1:0] m, input logic [5:0] aa, input logic [5:0] ab, input string tag);
    step(m, aa, ab, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, tag);
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        logic [3:0] got;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = {out_a, out_a5, out_b, shift_out};
        n_checks++;
        if (got !== e) begin
          n_fail++;
          $display("FAIL %s: {out_a,out_a5,out_b,shift_out} actual=%b expected=%b", t, got, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: everything reads zero after reset
    rd(2'd0, 6'd0, 6'd63, "R1");
    rd(2'd0, 6'd63, 6'd0, "R1");
    rd(2'd0, 6'd37, 6'd21, "R1");

    // R9: load both tables through the configuration port
    for (int i = 0; i < 64; i++)
      step(2'd0, 6'd0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'(i), ^6'(i), "R9");
    for (int i = 0; i < 64; i++)
      step(2'd0, 6'd0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'(i), (i % 3) == 0, "R9");

    // R2 and R7: full sweep of both functions, including the split outputs
    for (int i = 0; i < 64; i++)
      rd(2'd0, 6'(i), 6'(63 - i), "R2_R7");

    // R3: user writes in LUT mode are ignored
    step(2'd0, 6'd5, 6'd5, 1'b1, ~ma[5], 1'b1, 1'b0, 1'b0, 6'd0, 1'b0, "R3");
    rd(2'd0, 6'd5, 6'd5, "R3");
    rd(2'd0, 6'd0, 6'd0, "R3");

    // R4: RAM write then read back; cell B untouched
    step(2'd1, 6'd10, 6'd10, 1'b1, ~ma[10], 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, "R4");
    rd(2'd1, 6'd10, 6'd10, "R4");
    step(2'd1, 6'd63, 6'd63, 1'b1, ~ma[63], 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, "R4");
    rd(2'd1, 6'd63, 6'd63, "R4");

    // R6: no enable, no change
    step(2'd1, 6'd10, 6'd10, 1'b0, ~ma[10], 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, "R6");
    rd(2'd1, 6'd10, 6'd10, "R6");

    // R5: shift a pattern through, reading different taps
    for (int i = 0; i < 40; i++)
      step(2'd2, 6'(32 + (i % 32)), 6'd0, 1'b1, 1'b0, (i % 5) < 2, 1'b0, 1'b0, 6'd0, 1'b0, "R5");
    for (int i = 0; i < 32; i++)
      rd(2'd2, 6'(i), 6'd0, "R5_tap");
    // R6: shift mode idle keeps the chain
    step(2'd2, 6'd31, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 1'b0, "R6");
    rd(2'd2, 6'd31, 6'd0, "R6");
    // R5: upper half kept, visible in LUT mode
    rd(2'd0, 6'd63, 6'd0, "R5_upper");
    rd(2'd0, 6'd33, 6'd0, "R5_upper");

    // R8: dual-port write, independent second read address
    step(2'd3, 6'd20, 6'd7, 1'b1, ~ma[20], 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, "R8");
    rd(2'd3, 6'd7, 6'd20, "R8");
    rd(2'd3, 6'd20, 6'd20, "R8");
    step(2'd3, 6'd45, 6'd20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, "R8");
    rd(2'd3, 6'd2, 6'd45, "R8");

    // R9: configuration wins over a same-cycle user write
    step(2'd1, 6'd12, 6'd12, 1'b1, ~ma[12], 1'b0, 1'b1, 1'b1, 6'd3, ~mb[3], "R9");
    rd(2'd1, 6'd12, 6'd3, "R9");
    step(2'd2, 6'd0, 6'd0, 1'b1, 1'b0, ~ma[0], 1'b1, 1'b0, 6'd40, ~ma[40], "R9");
    rd(2'd0, 6'd40, 6'd0, "R9");
    rd(2'd2, 6'd0, 6'd0, "R9");

    // R7: split outputs with addr_a[5] high after the edits
    rd(2'd0, 6'd42, 6'd0, "R7");
    rd(2'd0, 6'd61, 6'd0, "R7");

    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule